// File: doc/BRIEF.md
# Pseudo-Random Noise Voice

This block produces the noise voice of a retro sound unit. A 15-bit shift register, clocked by a programmable period divider, supplies a pseudo-random bit stream. Whenever that bit is 1 and the voice is active, the output amplitude is the current envelope volume. A switch selects a short 7-bit sequence in place of the full 15-bit one, which gives a more tonal, metallic sound.

Software programs the voice through a byte-wide write port with four register slots: length, envelope, frequency and control. A CPU-rate clock enable drives the period divider. An external frame sequencer supplies separate strobes that step the length counter and the volume envelope. The block has two outputs: a 4-bit amplitude for a downstream mixer, and a flag that shows whether the voice is currently active.

Top module: `noise_voice`

## Requirements
- R1: After reset, `amp` is 0 and `active` is 0, and every stored field, the divider count and the shift register are zero.
- R2: A write to slot 2 stores the divider code from bits 2:0, the short-mode flag from bit 3 and the shift amount from bits 7:4. The period is base<<shift enabled CPU ticks, where base is 8 for code 0 and 16 times the code for codes 1 to 7.
- R3: At each period expiry while active, the feedback bit is bit0 XOR bit1. The register shifts right by one and the feedback enters bit 14. `amp` equals the envelope volume while the last feedback is 1 and the voice is active; otherwise `amp` is 0.
- R4: In short mode, the feedback bit is also written into bit 6 after the shift.
- R5: A write to slot 3 with bit 7 set does all of the following: it makes the voice active, loads 0x7FF1 into the shift register, reloads the divider, clears the held feedback bit and clears the envelope sub-counter. Bit 6 of every slot-3 write is stored as the length enable.
- R6: A write to slot 1 stores the pace from bits 2:0, the direction from bit 3 (1 = up) and the volume from bits 7:4, and it clears the sub-counter. While the voice is active and the pace is nonzero, the volume steps by one on every pace-th envelope strobe. The envelope stops once the volume reaches 0 or 15. With pace 0 the volume never changes.
- R7: A write to slot 0 loads the length count from bits 5:0. Each length strobe while active adds one to the count. Going from 63 to 0 clears `active` if the length enable is set, and leaves the voice active otherwise.
- R8: While `cpu_tick` is low, the divider holds its count and no expiry occurs.
- R9: A register write takes precedence over a length or envelope strobe in the same cycle. A trigger takes precedence over a divider expiry in the same cycle.
- R10: The divider reload holds the largest period, 112<<15, without truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | CPU-rate enable for the period divider |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Slot: 0 length, 1 envelope, 2 frequency, 3 control |
| wr_data | input | 8 | Write data |
| len_strobe | input | 1 | Length counter step from the sequencer |
| env_strobe | input | 1 | Envelope step from the sequencer |
| amp | output | 4 | Output amplitude |
| active | output | 1 | Voice active flag |

## Verification
On every cycle, the assertions check the following:
- the shift step, including the bit-6 copy in short mode, and the seed value after a trigger;
- that the divider reloads on expiry and freezes without a tick;
- that the volume moves by at most one step and holds once the envelope has stopped;
- that a length wrap with the enable set turns the voice off;
- that a nonzero amplitude implies the voice is active.

Some behaviours only the bench scenarios can show, because they follow from a whole sequence of events. These are the actual period lengths for each divider code and shift, the shape of the bit stream, the full envelope ramps, and the outcome when a write or trigger lands in the same cycle as a strobe or an expiry. The bench compares all of them against its behavioural model.

// File: rtl/noise_pkg.sv
package noise_pkg;

   typedef enum logic [1:0] {
      SLOT_LEN  = 2'd0,
      SLOT_ENV  = 2'd1,
      SLOT_FREQ = 2'd2,
      SLOT_CTRL = 2'd3
   } slot_e;

   localparam int CODE_W = 3;
   localparam int BASE_W = 7;

   // base period: 8 for code 0, 16*code otherwise
   function automatic logic [BASE_W-1:0] base_period(input logic [CODE_W-1:0] code);
      return (code == '0) ? BASE_W'(8) : {code, 4'b0000};
   endfunction

endpackage

// File: rtl/noise_period_timer.sv
module noise_period_timer
   import noise_pkg::*;
#(
   parameter int SHIFT_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                reload_now,
   input  logic [CODE_W-1:0]   code,
   input  logic [SHIFT_W-1:0]  shift,
   output logic                expire
);
   localparam int TMR_W = BASE_W + (1 << SHIFT_W) - 1;

   logic [TMR_W-1:0] cnt;
   logic [TMR_W-1:0] reload;

   assign reload = TMR_W'(base_period(code)) << shift;
   assign expire = tick && !reload_now && (cnt <= TMR_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (reload_now)
         cnt <= reload;
      else if (tick)
         cnt <= (cnt <= TMR_W'(1)) ? reload : cnt - 1'b1;
   end

   // R2
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == $past(reload)));

   // R8
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !reload_now) |=> $stable(cnt));

endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
   parameter int              W         = 15,
   parameter int              SHORT_TAP = 6,
   parameter logic [W-1:0]    SEED      = 15'h7FF1,
   parameter bit              SHORT_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seed,
   input  logic step,
   input  logic short_mode,
   output logic bit_q
);
   logic [W-1:0] state;
   logic [W-1:0] shifted;
   logic [W-1:0] nxt;
   logic         fb;

   assign fb      = state[0] ^ state[1];
   assign shifted = {fb, state[W-1:1]};

   generate
      if (SHORT_EN) begin : g_short
         always_comb begin
            nxt = shifted;
            if (short_mode) nxt[SHORT_TAP] = fb;
         end
         // R4
         short_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !seed && short_mode) |=> (state[SHORT_TAP] == state[W-1]));
      end else begin : g_long
         logic unused_short;
         assign unused_short = short_mode;
         assign nxt = shifted;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= '0;
         bit_q <= 1'b0;
      end else if (seed) begin
         state <= SEED;
         bit_q <= 1'b0;
      end else if (step) begin
         state <= nxt;
         bit_q <= fb;
      end
   end

   // R3
   shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !seed) |=> (state[W-1] == $past(state[0] ^ state[1])) &&
                          (state[W-2:SHORT_TAP+1] == $past(state[W-1:SHORT_TAP+2])));

   // R5
   seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed |=> (state == SEED) && !bit_q);

endmodule

// File: rtl/noise_envelope.sv
module noise_envelope #(
   parameter int VOL_W  = 4,
   parameter int PACE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [PACE_W-1:0] wr_pace,
   input  logic              wr_up,
   input  logic [VOL_W-1:0]  wr_vol,
   input  logic              clear_sub,
   input  logic              strobe,
   input  logic              active,
   output logic [VOL_W-1:0]  vol
);
   localparam logic [VOL_W-1:0] VMAX = '1;

   logic [PACE_W-1:0] pace;
   logic [PACE_W-1:0] sub;
   logic [PACE_W-1:0] sub_nx;
   logic              up;
   logic              run;
   logic [VOL_W-1:0]  vol_nx;

   assign sub_nx = sub + 1'b1;
   assign vol_nx = up ? ((vol == VMAX) ? vol : vol + 1'b1)
                      : ((vol == '0)   ? vol : vol - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pace <= '0;
         sub  <= '0;
         up   <= 1'b0;
         run  <= 1'b0;
         vol  <= '0;
      end else if (wr) begin
         pace <= wr_pace;
         up   <= wr_up;
         vol  <= wr_vol;
         run  <= (wr_pace != '0);
         sub  <= '0;
      end else if (clear_sub) begin
         sub <= '0;
      end else if (strobe && active && run) begin
         if (sub_nx >= pace) begin
            sub <= '0;
            vol <= vol_nx;
            if (vol_nx == '0 || vol_nx == VMAX) run <= 1'b0;
         end else begin
            sub <= sub_nx;
         end
      end
   end

   // R6
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !run) |=> $stable(vol));

   // R6
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (vol == $past(vol)) || (vol == $past(vol) + 1'b1) ||
              (vol == $past(vol) - 1'b1));

endmodule

// File: rtl/noise_length.sv
module noise_length #(
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_wr,
   input  logic [LEN_W-1:0] len_data,
   input  logic             ctrl_wr,
   input  logic             len_en_in,
   input  logic             trig,
   input  logic             strobe,
   output logic             active
);
   localparam logic [LEN_W-1:0] LMAX = '1;

   logic [LEN_W-1:0] cnt;
   logic             len_en;
   logic             wrap;

   assign wrap = strobe && active && !len_wr && (cnt == LMAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         len_en <= 1'b0;
         active <= 1'b0;
      end else begin
         if (len_wr)
            cnt <= len_data;
         else if (strobe && active)
            cnt <= cnt + 1'b1;

         if (ctrl_wr) len_en <= len_en_in;

         if (trig)
            active <= 1'b1;
         else if (wrap && len_en)
            active <= 1'b0;
      end
   end

   // R7
   wrap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && len_en && !trig) |=> !active);

   // R7
   wrap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !len_en) |=> active);

endmodule

// File: rtl/noise_voice.sv
module noise_voice
   import noise_pkg::*;
#(
   parameter int           LFSR_W    = 15,
   parameter int           SHORT_TAP = 6,
   parameter logic [14:0]  SEED      = 15'h7FF1,
   parameter bit           SHORT_EN  = 1'b1,
   parameter int           VOL_W     = 4,
   parameter int           PACE_W    = 3,
   parameter int           LEN_W     = 6,
   parameter int           SHIFT_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_tick,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [7:0]       wr_data,
   input  logic             len_strobe,
   input  logic             env_strobe,
   output logic [VOL_W-1:0] amp,
   output logic             active
);
   localparam int TRIG_BIT   = 7;
   localparam int LENEN_BIT  = 6;
   localparam int SHORT_BIT  = CODE_W;
   localparam int SHIFT_LSB  = CODE_W + 1;
   localparam int VOL_LSB    = PACE_W + 1;

   generate
      if (VOL_W + PACE_W + 1 > 8) begin : g_bad_env
         $error("envelope fields exceed the write byte");
      end
      if (SHIFT_LSB + SHIFT_W > 8) begin : g_bad_freq
         $error("frequency fields exceed the write byte");
      end
      if (LEN_W > LENEN_BIT) begin : g_bad_len
         $error("length field too wide");
      end
      if (SHORT_TAP + 2 >= LFSR_W) begin : g_bad_tap
         $error("short tap must sit below the top two bits");
      end
   endgenerate

   logic               wr_len, wr_env, wr_freq, wr_ctrl, trig;
   logic [CODE_W-1:0]  code_q;
   logic               short_q;
   logic [SHIFT_W-1:0] shift_q;
   logic               expire;
   logic               noise_bit;
   logic [VOL_W-1:0]   vol;

   assign wr_len  = wr_en && (wr_sel == SLOT_LEN);
   assign wr_env  = wr_en && (wr_sel == SLOT_ENV);
   assign wr_freq = wr_en && (wr_sel == SLOT_FREQ);
   assign wr_ctrl = wr_en && (wr_sel == SLOT_CTRL);
   assign trig    = wr_ctrl && wr_data[TRIG_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= '0;
         short_q <= 1'b0;
         shift_q <= '0;
      end else if (wr_freq) begin
         code_q  <= wr_data[CODE_W-1:0];
         short_q <= wr_data[SHORT_BIT];
         shift_q <= wr_data[SHIFT_LSB +: SHIFT_W];
      end
   end

   noise_period_timer #(.SHIFT_W(SHIFT_W)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (cpu_tick),
      .reload_now (trig),
      .code       (code_q),
      .shift      (shift_q),
      .expire     (expire)
   );

   noise_lfsr #(
      .W         (LFSR_W),
      .SHORT_TAP (SHORT_TAP),
      .SEED      (LFSR_W'(SEED)),
      .SHORT_EN  (SHORT_EN)
   ) i_lfsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .seed       (trig),
      .step       (expire && active),
      .short_mode (short_q),
      .bit_q      (noise_bit)
   );

   noise_envelope #(.VOL_W(VOL_W), .PACE_W(PACE_W)) i_env (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_env),
      .wr_pace   (wr_data[PACE_W-1:0]),
      .wr_up     (wr_data[PACE_W]),
      .wr_vol    (wr_data[VOL_LSB +: VOL_W]),
      .clear_sub (trig),
      .strobe    (env_strobe),
      .active    (active),
      .vol       (vol)
   );

   noise_length #(.LEN_W(LEN_W)) i_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .len_wr    (wr_len),
      .len_data  (wr_data[LEN_W-1:0]),
      .ctrl_wr   (wr_ctrl),
      .len_en_in (wr_data[LENEN_BIT]),
      .trig      (trig),
      .strobe    (len_strobe),
      .active    (active)
   );

   assign amp = (active && noise_bit) ? vol : '0;

   // R3
   amp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (amp != '0) |-> active);

endmodule

// File: tb/test_noise_voice.sv
module test_noise_voice;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       len_strobe = 1'b0;
   logic       env_strobe = 1'b0;
   logic [3:0] amp;
   logic       active;

   always #4 clk = ~clk;

   noise_voice i_noise_voice (
      .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .len_strobe(len_strobe),
      .env_strobe(env_strobe), .amp(amp), .active(active)
   );

   int    vectors = 0;
   int    fails = 0;
   int    cyc = 0;
   int    tick_div = 1;
   int    env_per = 0;
   int    len_per = 0;
   bit    comparing = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_cnt, m_lfsr, m_bit, m_code, m_short, m_shift;
   int m_pace, m_up, m_vol, m_run, m_sub;
   int m_len, m_len_en, m_active, m_amp;

   function automatic int period(input int code, input int sh);
      int b;
      b = (code == 0) ? 8 : 16 * code;
      return b << sh;
   endfunction

   always @(posedge clk) begin
      int fb, nact;
      bit trig, expire;
      if (!rst_n) begin
         m_cnt = 0; m_lfsr = 0; m_bit = 0; m_code = 0; m_short = 0; m_shift = 0;
         m_pace = 0; m_up = 0; m_vol = 0; m_run = 0; m_sub = 0;
         m_len = 0; m_len_en = 0; m_active = 0;
      end else begin
         trig = wr_en && wr_sel == 2'd3 && wr_data[7];
         expire = 0;
         if (trig) m_cnt = period(m_code, m_shift);
         else if (cpu_tick) begin
            if (m_cnt <= 1) begin expire = 1; m_cnt = period(m_code, m_shift); end
            else m_cnt = m_cnt - 1;
         end
         if (trig) begin m_lfsr = 'h7FF1; m_bit = 0; end
         else if (expire && m_active != 0) begin
            fb = (m_lfsr & 1) ^ ((m_lfsr >> 1) & 1);
            m_lfsr = (m_lfsr >> 1) | (fb << 14);
            if (m_short != 0) m_lfsr = (m_lfsr & ~(1 << 6)) | (fb << 6);
            m_bit = fb;
         end
         if (wr_en && wr_sel == 2'd1) begin
            m_pace = int'(wr_data[2:0]); m_up = int'(wr_data[3]);
            m_vol = int'(wr_data[7:4]); m_run = (m_pace != 0); m_sub = 0;
         end else if (trig) m_sub = 0;
         else if (env_strobe && m_active != 0 && m_run != 0) begin
            m_sub = m_sub + 1;
            if (m_sub >= m_pace) begin
               m_sub = 0;
               if (m_up != 0) begin if (m_vol < 15) m_vol = m_vol + 1; end
               else begin if (m_vol > 0) m_vol = m_vol - 1; end
               if (m_vol == 0 || m_vol == 15) m_run = 0;
            end
         end
         nact = m_active;
         if (wr_en && wr_sel == 2'd0) m_len = int'(wr_data[5:0]);
         else if (len_strobe && m_active != 0) begin
            if (m_len == 63) begin m_len = 0; if (m_len_en != 0) nact = 0; end
            else m_len = m_len + 1;
         end
         if (wr_en && wr_sel == 2'd3) m_len_en = int'(wr_data[6]);
         if (trig) nact = 1;
         m_active = nact;
         if (wr_en && wr_sel == 2'd2) begin
            m_code = int'(wr_data[2:0]); m_short = int'(wr_data[3]);
            m_shift = int'(wr_data[7:4]);
         end
      end
      m_amp = (m_active != 0 && m_bit != 0) ? m_vol : 0;
   end

   always @(negedge clk) begin
      if (comparing) begin
         vectors++;
         if (int'(amp) != m_amp || int'(active) != m_active) begin
            fails++;
            $display("FAIL %s cycle %0d: amp=%0d active=%0d expected amp=%0d active=%0d",
                     cur_req, cyc, amp, active, m_amp, m_active);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input bit w, input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      cyc++;
      cpu_tick   = (tick_div <= 1) || (cyc % tick_div == 0);
      env_strobe = (env_per > 0) && (cyc % env_per == 0);
      len_strobe = (len_per > 0) && (cyc % len_per == 0);
      wr_en = w; wr_sel = s; wr_data = d;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 8'd0);
   endtask

   task automatic wreg(input logic [1:0] s, input logic [7:0] d);
      drive(1'b1, s, d);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1 amp", int'(amp), 0);
      chk("R1 active", int'(active), 0);
      comparing = 1;
      run(20);

      cur_req = "R3";
      wreg(2'd1, 8'hF0);
      wreg(2'd2, 8'h00);
      wreg(2'd3, 8'h80);
      run(1);
      cur_req = "R5";
      chk("R5 held bit cleared", int'(amp), 0);
      chk("R5 active", int'(active), 1);
      cur_req = "R3";
      run(400);

      cur_req = "R4";
      wreg(2'd2, 8'h08);
      run(400);

      cur_req = "R2";
      wreg(2'd2, 8'h32);
      wreg(2'd3, 8'h80);
      run(2500);
      wreg(2'd2, 8'h1D);
      wreg(2'd3, 8'h80);
      run(2500);

      cur_req = "R8";
      wreg(2'd2, 8'h01);
      tick_div = 3;
      wreg(2'd3, 8'h80);
      run(900);
      tick_div = 1;

      cur_req = "R6";
      wreg(2'd2, 8'h00);
      env_per = 4;
      wreg(2'd1, 8'h71);
      wreg(2'd3, 8'h80);
      run(200);
      chk("R6 volume decayed to 0", int'(amp), 0);
      chk("R6 still active", int'(active), 1);
      wreg(2'd1, 8'h3A);
      run(300);
      wreg(2'd1, 8'h90);
      run(200);

      cur_req = "R7";
      env_per = 0;
      len_per = 5;
      wreg(2'd1, 8'hF0);
      wreg(2'd0, 8'h3C);
      wreg(2'd3, 8'hC0);
      run(40);
      chk("R7 length wrap disables", int'(active), 0);
      run(20);
      wreg(2'd0, 8'h3E);
      wreg(2'd3, 8'h80);
      run(40);
      chk("R7 wrap without enable keeps active", int'(active), 1);

      cur_req = "R9";
      len_per = 1;
      env_per = 1;
      wreg(2'd1, 8'h52);
      wreg(2'd0, 8'h3F);
      wreg(2'd3, 8'hC0);
      for (int k = 0; k < 12; k++) begin
         run(5 + k);
         wreg(2'd1, 8'hA1);
         wreg(2'd0, 8'h30);
         wreg(2'd3, 8'h80);
      end
      len_per = 0;
      env_per = 0;
      for (int k = 0; k < 10; k++) begin
         run(7);
         wreg(2'd3, 8'h80);
      end

      cur_req = "R10";
      wreg(2'd1, 8'hF0);
      wreg(2'd2, 8'hF7);
      wreg(2'd3, 8'h80);
      run(3000);
      chk("R10 long period not yet expired", int'(amp), 0);
      chk("R10 active", int'(active), 1);

      comparing = 0;
      summary();
      $finish;
   end
endmodule